// File: doc/BRIEF.md
# Synthesizer I2C Control Register Interface

This block is a standard-mode I2C slave that loads the programming registers of a frequency synthesizer and returns one status byte. A fast system clock oversamples SCL and SDA through a short synchronizer. SDA is handled as an input plus a pull-low enable for an external open-drain pad. START and STOP are recognised while SCL is high. After a START the first byte is the address. Its top five bits are a fixed device code. The next two bits must equal the strap input `hw_addr_i`, so four of these blocks can share one bus. The last bit picks the direction.

In a write transaction there is no sub-address pointer. The leading bit of each data byte sets its meaning. A byte with MSB 0 opens a two-byte divider load, and the next byte always completes it. A byte with MSB 1 is the control byte, and the byte after it is always the band/test byte. Bytes can follow one another until STOP, so the master can sweep the divider without sending the address again.

In a read transaction the slave shifts out a status byte built from a power-on flag, the lock input, three comparator bits and a 3-bit level code. The power-on flag is set by reset. It clears once a complete status byte has been shifted out.

Top module: `synth_i2c_ctl`

## Requirements
- R1: The address byte is 1,1,0,0,0,A1,A0,RW, MSB first. It is accepted only when A1:A0 equals `hw_addr_i`. RW=0 selects write and RW=1 selects read. A byte with any other address gets no acknowledge, and the data bytes after it change no output.
- R2: The slave pulls SDA low for the ninth clock of an accepted address byte. In write mode it also pulls SDA low for the ninth clock of every data byte.
- R3: In a write, a data byte whose MSB is 0 holds divider bits 14..8 in its bits 6..0. The next byte holds divider bits 7..0. `divider_o[14:0]` is updated only when that second byte completes. A first divider byte that is not followed by its partner changes nothing.
- R4: A data byte whose MSB is 1 is the control byte and is applied when it completes. In that byte, bit 5 goes to `divider_o[15]`, bits 4:3 go to `pump_cur_o`, bit 1 goes to `step_coarse_o` and bit 0 goes to `tune_off_o`. Bits 6 and 2 are ignored.
- R5: The byte after a control byte is the band byte and is applied when it completes. Bits 7:5 go to `test_o`, bit 3 goes to `band2_o` and bit 0 goes to `band1_o`. Bits 4, 2 and 1 are ignored.
- R6: Divider pairs, control bytes and band bytes can follow each other in one transaction without a new address. START and STOP return the byte-type sequence to its first step.
- R7: An aborted transfer leaves every register that was already applied unchanged.
- R8: The read status byte, MSB first, is {POR, `lock_i`, `cmp_i[2]`, `cmp_i[1]`, `cmp_i[0]`, `adc_lvl_i[2:0]`}. A not-acknowledge from the master ends the read.
- R9: The POR flag is 1 after reset. It goes to 0 after the eighth clock of a status byte has been sent.
- R10: After reset, `divider_o`=0, `pump_cur_o`=00, `step_coarse_o`=1, `tune_off_o`=1, `test_o`=000, both band outputs are 0, and SDA is released.
- R11: A START or STOP in the middle of a byte discards the partial byte. After a START the next byte is taken as an address.
- R12: `sda_pull_o` changes only while SCL is low. It is never asserted while the slave is not addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain SDA pad |
| hw_addr_i | input | 2 | Strapped address bits that are compared with A1:A0 |
| lock_i | input | 1 | Synthesizer lock flag, reported in the status byte |
| cmp_i | input | 3 | Comparator input bits, [2] sent first |
| adc_lvl_i | input | 3 | Level code from the converter |
| divider_o | output | 16 | Loop divider ratio |
| pump_cur_o | output | 2 | Charge-pump current code |
| step_coarse_o | output | 1 | 1 selects the coarse (short) reference divide |
| tune_off_o | output | 1 | 1 turns the tuning amplifier off |
| test_o | output | 3 | Test-mode code |
| band1_o | output | 1 | Band switch 1 enable |
| band2_o | output | 1 | Band switch 2 enable |

## Verification
A wrong byte-type state sends a data byte to the wrong register. This shows on the outputs a few system clocks after the eighth SCL rise of that byte, and the per-clock comparison against the bench model catches it there. A bit counter that is off by one shows at the port within one byte as a missing or misplaced acknowledge pulse or a shifted status byte. A power-on flag that is not cleared shows up only on the second read. For that reason the bench reads the status byte twice.

// File: rtl/synth_i2c_ctl.sv
module synth_i2c_ctl #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [4:0]  DEV_ID      = 5'b11000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  input  logic [1:0]  hw_addr_i,
  input  logic        lock_i,
  input  logic [2:0]  cmp_i,
  input  logic [2:0]  adc_lvl_i,
  output logic [15:0] divider_o,
  output logic [1:0]  pump_cur_o,
  output logic        step_coarse_o,
  output logic        tune_off_o,
  output logic [2:0]  test_o,
  output logic        band1_o,
  output logic        band2_o
);

  localparam int LAST = SYNC_STAGES - 1;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_WR, PH_RD} phase_t;
  typedef enum logic [1:0] {K_ANY, K_LOW, K_BAND} kind_t;

  logic [LAST:0] scl_pipe, sda_pipe;
  logic          scl_q, sda_q;
  wire           scl_s = scl_pipe[LAST];
  wire           sda_s = sda_pipe[LAST];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
      sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  phase_t     phase;
  kind_t      kind;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, tx;
  logic [6:0] hi_hold;
  logic       ack_go, rd_sel, por_q;

  wire [7:0] byte_in  = {shreg[6:0], sda_s};
  wire       addr_hit = (byte_in[7:3] == DEV_ID) && (byte_in[2:1] == hw_addr_i);
  wire [7:0] status   = {por_q, lock_i, cmp_i, adc_lvl_i};
  wire [2:0] tx_idx   = 3'(4'd7 - bit_cnt);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase         <= PH_IDLE;
      kind          <= K_ANY;
      bit_cnt       <= '0;
      shreg         <= '0;
      tx            <= '0;
      hi_hold       <= '0;
      ack_go        <= 1'b0;
      rd_sel        <= 1'b0;
      por_q         <= 1'b1;
      sda_pull_o    <= 1'b0;
      divider_o     <= '0;
      pump_cur_o    <= 2'b00;
      step_coarse_o <= 1'b1;
      tune_off_o    <= 1'b1;
      test_o        <= 3'b000;
      band1_o       <= 1'b0;
      band2_o       <= 1'b0;
    end else if (start_c || stop_c) begin
      phase      <= start_c ? PH_ADDR : PH_IDLE;
      kind       <= K_ANY;
      bit_cnt    <= '0;
      ack_go     <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (scl_rise && phase != PH_IDLE) begin
      if (bit_cnt != 4'd8) begin
        shreg   <= byte_in;
        bit_cnt <= bit_cnt + 4'd1;
        if (bit_cnt == 4'd7) begin
          unique case (phase)
            PH_ADDR:
              if (addr_hit) begin
                ack_go <= 1'b1;
                rd_sel <= byte_in[0];
              end else
                phase <= PH_IDLE;
            PH_WR: begin
              ack_go <= 1'b1;
              unique case (kind)
                K_LOW: begin
                  divider_o[14:0] <= {hi_hold, byte_in};
                  kind            <= K_ANY;
                end
                K_BAND: begin
                  test_o  <= byte_in[7:5];
                  band2_o <= byte_in[3];
                  band1_o <= byte_in[0];
                  kind    <= K_ANY;
                end
                default:
                  if (!byte_in[7]) begin
                    hi_hold <= byte_in[6:0];
                    kind    <= K_LOW;
                  end else begin
                    divider_o[15] <= byte_in[5];
                    pump_cur_o    <= byte_in[4:3];
                    step_coarse_o <= byte_in[1];
                    tune_off_o    <= byte_in[0];
                    kind          <= K_BAND;
                  end
              endcase
            end
            PH_RD: por_q <= 1'b0;
            default: ;
          endcase
        end
      end else begin
        bit_cnt <= '0;
        ack_go  <= 1'b0;
        if (phase == PH_ADDR)
          phase <= rd_sel ? PH_RD : PH_WR;
        else if (phase == PH_RD && sda_s)
          phase <= PH_IDLE;
      end
    end else if (scl_fall) begin
      if (phase == PH_IDLE)
        sda_pull_o <= 1'b0;
      else if (bit_cnt == 4'd8)
        sda_pull_o <= ack_go;
      else if (phase == PH_RD) begin
        if (bit_cnt == 4'd0) begin
          tx         <= status;
          sda_pull_o <= ~status[7];
        end else
          sda_pull_o <= ~tx[tx_idx];
      end else
        sda_pull_o <= 1'b0;
    end

  // R12
  pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s);

  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_pull_o);

  // R9
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> $past(phase) == PH_RD);

  // R3
  div_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divider_o[14:0]) |-> ($past(phase) == PH_WR && $past(kind) == K_LOW));

  // R4
  ctrl_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({divider_o[15], pump_cur_o, step_coarse_o, tune_off_o})
      |-> ($past(phase) == PH_WR && $past(kind) == K_ANY));

  // R5
  band_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({test_o, band1_o, band2_o}) |-> ($past(phase) == PH_WR && $past(kind) == K_BAND));

endmodule

// File: tb/synth_i2c_ctl_test.sv
module synth_i2c_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] hw_addr = 2'b10;
  logic lock = 1'b0;
  logic [2:0] cmp = 3'b000, adc = 3'b000;
  wire  sda_pull;
  wire  sda_line = sda_m & ~sda_pull;
  wire [15:0] divider;
  wire [1:0]  pump;
  wire        coarse, toff, b1, b2;
  wire [2:0]  test;

  int vectors = 0, miscompares = 0;
  bit done = 0, cmp_en = 0, wr_live = 0;

  logic [14:0] e_lo = 0;
  logic e_n15 = 0, e_rs = 1, e_os = 1, e_b1 = 0, e_b2 = 0, e_por = 1;
  logic [1:0] e_cp = 0;
  logic [2:0] e_test = 0;
  logic [6:0] e_hi = 0;
  int e_kind = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_i2c_ctl uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .hw_addr_i(hw_addr), .lock_i(lock), .cmp_i(cmp), .adc_lvl_i(adc),
    .divider_o(divider), .pump_cur_o(pump), .step_coarse_o(coarse), .tune_off_o(toff),
    .test_o(test), .band1_o(b1), .band2_o(b2));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk)
    if (cmp_en && rst_n && !done) begin
      chk(divider == {e_n15, e_lo}, "R3 divider", 32'(divider), 32'({e_n15, e_lo}));
      chk({pump, coarse, toff} == {e_cp, e_rs, e_os}, "R4 control", 32'({pump, coarse, toff}), 32'({e_cp, e_rs, e_os}));
      chk({test, b2, b1} == {e_test, e_b2, e_b1}, "R5 band", 32'({test, b2, b1}), 32'({e_test, e_b2, e_b1}));
    end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_byte(input logic [7:0] b);
    if (e_kind == 1) begin
      e_lo = {e_hi, b}; e_kind = 0;
    end else if (e_kind == 2) begin
      e_test = b[7:5]; e_b2 = b[3]; e_b1 = b[0]; e_kind = 0;
    end else if (!b[7]) begin
      e_hi = b[6:0]; e_kind = 1;
    end else begin
      e_n15 = b[5]; e_cp = b[4:3]; e_rs = b[1]; e_os = b[0]; e_kind = 2;
    end
  endtask

  task automatic bus_start();
    sda_m = 1; wclk(HALF); scl = 1; wclk(HALF);
    sda_m = 0; wclk(HALF); scl = 0; wclk(HALF);
    e_kind = 0;
  endtask

  task automatic bus_stop();
    sda_m = 0; wclk(HALF); scl = 1; wclk(HALF); sda_m = 1; wclk(HALF);
    e_kind = 0; wr_live = 0;
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wclk(HALF); scl = 1; wclk(HALF); scl = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit is_data, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) cmp_en = 0;
      put_bit(b[i]);
    end
    if (is_data && wr_live) model_byte(b);
    cmp_en = 1;
    sda_m = 1; wclk(HALF); scl = 1; wclk(HALF/2);
    acked = ~sda_line;
    wclk(HALF/2); scl = 0;
  endtask

  task automatic read_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; wclk(HALF); scl = 1; wclk(HALF/2);
      d[i] = sda_line;
      wclk(HALF/2); scl = 0;
    end
    sda_m = ~mack; wclk(HALF); scl = 1; wclk(HALF); scl = 0; wclk(1); sda_m = 1;
  endtask

  task automatic write_seq(input logic [7:0] addr, input logic [7:0] data[$], input bit exp_ack, input string tag);
    logic a;
    bus_start();
    send_byte(addr, 0, a);
    chk(a == exp_ack, {tag, " R1 address ack"}, 32'(a), 32'(exp_ack));
    wr_live = exp_ack;
    foreach (data[k]) begin
      send_byte(data[k], 1, a);
      chk(a == exp_ack, {tag, " R2 data ack"}, 32'(a), 32'(exp_ack));
    end
    bus_stop();
    wclk(4);
    chk(sda_pull == 1'b0, {tag, " R12 released"}, 32'(sda_pull), 0);
  endtask

  task automatic read_status(input string tag);
    logic a;
    logic [7:0] d;
    logic [7:0] exp;
    bus_start();
    send_byte(8'hC5, 0, a);
    chk(a == 1'b1, {tag, " R1 read address ack"}, 32'(a), 1);
    exp = {e_por, lock, cmp, adc};
    read_byte(0, d);
    chk(d == exp, {tag, " R8 R9 status byte"}, 32'(d), 32'(exp));
    e_por = 0;
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: run did not finish act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic a;
    wclk(5); rst_n = 1; wclk(5);
    // R10 reset state
    chk(divider == 16'h0, "R10 divider", 32'(divider), 0);
    chk({pump, coarse, toff} == 4'b0011, "R10 control", 32'({pump, coarse, toff}), 32'h3);
    chk({test, b2, b1} == 5'b0, "R10 band", 32'({test, b2, b1}), 0);
    chk(sda_pull == 1'b0, "R10 sda", 32'(sda_pull), 0);
    cmp_en = 1;

    // R3 divider pair
    write_seq(8'hC4, '{8'h3A, 8'hBC}, 1, "T2");
    chk(divider == 16'h3ABC, "R3 pair", 32'(divider), 32'h3ABC);

    // R3 lone first byte, R7 abort keeps value
    write_seq(8'hC4, '{8'h15}, 1, "T3");
    chk(divider == 16'h3ABC, "R3 R7 lone byte", 32'(divider), 32'h3ABC);

    // R6 stream: control, band, pair, control, band
    write_seq(8'hC4, '{8'hB6, 8'hA9, 8'h01, 8'h23, 8'h81, 8'h56}, 1, "T4");
    chk(divider == 16'h0123, "R6 R4 stream divider", 32'(divider), 32'h0123);
    chk({pump, coarse, toff} == 4'b0001, "R4 control bits", 32'({pump, coarse, toff}), 32'h1);
    chk({test, b2, b1} == 5'b01000, "R5 band bits", 32'({test, b2, b1}), 32'h08);

    // R4 ignored control bits 6 and 2; R5 band then
    write_seq(8'hC4, '{8'hB6, 8'hA9}, 1, "T4b");
    chk(divider == 16'h8123, "R4 n15", 32'(divider), 32'h8123);
    chk({pump, coarse, toff} == 4'b1010, "R4 cp rs os", 32'({pump, coarse, toff}), 32'hA);
    chk({test, b2, b1} == 5'b10111, "R5 t b2 b1", 32'({test, b2, b1}), 32'h17);
    write_seq(8'hC4, '{8'hC4, 8'h00}, 1, "T8");
    chk({divider[15], pump, coarse, toff} == 5'b0, "R4 ignored bits", 32'({divider[15], pump, coarse, toff}), 0);

    // R1 wrong address ignored
    write_seq(8'hC0, '{8'h7F, 8'hFF, 8'hFF}, 0, "T5");
    chk(divider == 16'h0123, "R1 foreign divider", 32'(divider), 32'h0123);

    // R8 R9 status reads
    lock = 1; cmp = 3'b101; adc = 3'b011;
    read_status("T6a");
    lock = 0; cmp = 3'b010; adc = 3'b100;
    read_status("T6b");

    // R11 mid-byte repeated START
    bus_start();
    send_byte(8'hC4, 0, a); wr_live = 1;
    put_bit(0); put_bit(1); put_bit(1); put_bit(1);
    bus_start();
    send_byte(8'hC4, 0, a);
    chk(a == 1'b1, "R11 address after restart", 32'(a), 1);
    send_byte(8'h12, 1, a); send_byte(8'h34, 1, a);
    bus_stop();
    chk(divider == 16'h1234, "R11 restart pair", 32'(divider), 32'h1234);

    // R11 mid-byte STOP, R7
    bus_start();
    send_byte(8'hC4, 0, a); wr_live = 1;
    put_bit(1); put_bit(0); put_bit(1);
    bus_stop();
    chk({pump, coarse, toff} == 4'b0000, "R7 partial control", 32'({pump, coarse, toff}), 0);
    write_seq(8'hC4, '{8'h05, 8'h55}, 1, "T7");
    chk(divider == 16'h0555, "R11 after stop", 32'(divider), 32'h0555);

    wclk(10);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule